// File: doc/BRIEF.md
# Ethernet MAC/DMA Interrupt Combiner

This block gathers interrupt events from an Ethernet MAC core and its DMA engine and drives two lines into a vectored interrupt controller. The first line, `irq_wake`, carries the power-management wake condition. The second line, `irq_sys`, is the general system interrupt.

The MAC side has two level sources:
- the power-management module;
- the statistics counter module.

Each level source is captured into a read-only status bit. The power-management bit has an active-high mask in a separate mask word.

The DMA side has four event pulses. Each pulse sets a sticky status bit, and software clears the bit by writing a 1 to it. An enable word gates each sticky bit. The gated bits are folded into two registered summaries:
- a normal summary, from transmit completion;
- an abnormal summary, from early receive, transmit stopped and fatal bus error.

Each summary is gated again by its own enable before it reaches the general line. The counter level and the masked wake condition reach the general line directly and bypass all DMA gating.

Software reads and writes the four words through a word-addressed port. The port writes in one cycle and returns read data combinationally.

Top module: `eth_irq_merge`

## Requirements
- R1: After reset every register is zero, `irq_wake` and `irq_sys` are low, and every read returns zero until an event arrives.
- R2: Address 0 is the MAC status word. Bit 3 shows the `ev_pm` level and bit 4 shows the `ev_cnt` level, each as sampled at the previous clock edge. All other bits read zero, and writes to address 0 have no effect.
- R3: `irq_wake` is high exactly when MAC status bit 3 is set and bit 3 of the MAC mask word (address 1) is clear.
- R4: Address 2 is the DMA status word. Its sticky bits are:
  - bit 0, transmit done (`ev_tx`);
  - bit 1, early receive (`ev_rxerr`);
  - bit 2, transmit stopped (`ev_txstop`);
  - bit 3, fatal bus error (`ev_buserr`).

  A one-cycle pulse sets its bit at the next edge, and the bit then stays set.
- R5: Writing to address 2 clears each sticky bit whose write-data bit is 1 and leaves the others unchanged. A set and a clear of the same bit in the same cycle leave the bit set.
- R6: DMA status bit 16 is the registered normal summary. It equals DMA status bit 0 AND DMA enable bit 0 (address 3) as they stood one clock earlier, and writes cannot change it.
- R7: DMA status bit 15 is the registered abnormal summary. It is the OR, one clock late, of the following pairs, and writes cannot change it:
  - status bit 1 AND enable bit 1;
  - status bit 2 AND enable bit 2;
  - status bit 3 AND enable bit 3.
- R8: `irq_sys` is the OR of four terms:
  - the normal summary AND enable bit 16;
  - the abnormal summary AND enable bit 15;
  - MAC status bit 4;
  - `irq_wake`.
- R9: Addresses 1 and 3 are plain 32-bit read/write words. Addresses 4 to 7 read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 3 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data |
| ev_pm | input | 1 | Power-management interrupt level |
| ev_cnt | input | 1 | Counter-module interrupt level |
| ev_tx | input | 1 | Transmit-done pulse |
| ev_rxerr | input | 1 | Early-receive pulse |
| ev_txstop | input | 1 | Transmit-stopped pulse |
| ev_buserr | input | 1 | Fatal bus-error pulse |
| irq_wake | output | 1 | Power-management wake interrupt |
| irq_sys | output | 1 | General system interrupt |

## Verification
The bench runs three phases. Each phase is compared on every cycle against a behavioural model.

- **Enables off, no writes except clears.** Sticky bits can collect while `irq_sys` must follow only the counter and wake levels. This separates the two direct paths from the DMA summaries.
- **Every enable set and the mask set.** Each pulse must reach the general line two edges later while `irq_wake` stays silent. This exposes a missing summary register, a wrong summary-to-enable pairing, or an inverted mask.
- **Dense random events with random writes.** This phase frequently lands a clear on the same bit and cycle as its set, and it writes all-ones to the read-only and unused addresses. It tells set-priority and write protection apart from plain clearing.

// File: rtl/eth_irq_merge.sv
module eth_irq_merge #(
  parameter int AW      = 3,
  parameter int DW      = 32,
  parameter int PM_BIT  = 3,
  parameter int CNT_BIT = 4,
  parameter int NIS_BIT = 16,
  parameter int AIS_BIT = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          ev_pm,
  input  logic          ev_cnt,
  input  logic          ev_tx,
  input  logic          ev_rxerr,
  input  logic          ev_txstop,
  input  logic          ev_buserr,
  output logic          irq_wake,
  output logic          irq_sys
);
  localparam logic [AW-1:0] A_MSTAT = AW'(0);
  localparam logic [AW-1:0] A_MMASK = AW'(1);
  localparam logic [AW-1:0] A_DSTAT = AW'(2);
  localparam logic [AW-1:0] A_DEN   = AW'(3);
  localparam int NEV = 4;

  logic          pm_q, cnt_q, nis_q, ais_q;
  logic [DW-1:0] mask_q, en_q;
  logic [NEV-1:0] ds_q;

  wire [NEV-1:0] ev_set = {ev_buserr, ev_txstop, ev_rxerr, ev_tx};
  wire [NEV-1:0] ds_clr = (reg_wr && reg_addr == A_DSTAT) ? reg_wdata[NEV-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pm_q   <= 1'b0;
      cnt_q  <= 1'b0;
      mask_q <= '0;
      en_q   <= '0;
      ds_q   <= '0;
      nis_q  <= 1'b0;
      ais_q  <= 1'b0;
    end else begin
      pm_q  <= ev_pm;
      cnt_q <= ev_cnt;
      if (reg_wr && reg_addr == A_MMASK) mask_q <= reg_wdata;
      if (reg_wr && reg_addr == A_DEN)   en_q   <= reg_wdata;
      ds_q  <= ev_set | (ds_q & ~ds_clr);
      nis_q <= ds_q[0] & en_q[0];
      ais_q <= |(ds_q[NEV-1:1] & en_q[NEV-1:1]);
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_MSTAT: begin
        reg_rdata[PM_BIT]  = pm_q;
        reg_rdata[CNT_BIT] = cnt_q;
      end
      A_MMASK: reg_rdata = mask_q;
      A_DSTAT: begin
        reg_rdata[NEV-1:0] = ds_q;
        reg_rdata[NIS_BIT] = nis_q;
        reg_rdata[AIS_BIT] = ais_q;
      end
      A_DEN:   reg_rdata = en_q;
      default: reg_rdata = '0;
    endcase
  end

  assign irq_wake = pm_q & ~mask_q[PM_BIT];
  assign irq_sys  = (nis_q & en_q[NIS_BIT]) | (ais_q & en_q[AIS_BIT]) | cnt_q | irq_wake;
endmodule

// File: rtl/eth_irq_merge_chk.sv
module eth_irq_merge_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [2:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic [31:0] reg_rdata,
  input logic        ev_pm,
  input logic        ev_cnt,
  input logic        ev_tx,
  input logic        irq_wake,
  input logic        irq_sys
);
  p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |-> (!irq_wake && !irq_sys && reg_rdata == 32'h0));

  p_wake_needs_pm_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_pm |=> !irq_wake);

  p_wake_feeds_sys_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_wake |-> irq_sys);

  p_cnt_direct_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cnt |=> irq_sys);

  p_tx_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tx |=> (reg_addr != 3'd2 || reg_rdata[0]));

  p_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd2 && reg_wdata[0] && !ev_tx) |=> (reg_addr != 3'd2 || !reg_rdata[0]));

  p_mask_rw_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd1) |=> (reg_addr != 3'd1 || reg_rdata == $past(reg_wdata)));
endmodule

bind eth_irq_merge eth_irq_merge_chk u_chk (.*);

// File: tb/eth_irq_merge_bench.sv
`timescale 1ns/1ps
module eth_irq_merge_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic ev_pm = 0, ev_cnt = 0, ev_tx = 0, ev_rxerr = 0, ev_txstop = 0, ev_buserr = 0;
  logic irq_wake, irq_sys;

  always #4 clk = ~clk;

  eth_irq_merge u_eth_irq_merge (.*);

  int vectors = 0, errors = 0;
  bit done = 0;

  // behavioural model
  bit m_pm, m_cnt, m_nis, m_ais;
  bit [31:0] m_mask, m_en;
  bit [3:0] m_ds;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pm = 0; m_cnt = 0; m_nis = 0; m_ais = 0; m_mask = 0; m_en = 0; m_ds = 0;
    end else begin
      bit nn, na;
      bit [3:0] ev, nds;
      nn = m_ds[0] && m_en[0];
      na = (m_ds[1] && m_en[1]) || (m_ds[2] && m_en[2]) || (m_ds[3] && m_en[3]);
      ev = {ev_buserr, ev_txstop, ev_rxerr, ev_tx};
      nds = m_ds;
      for (int i = 0; i < 4; i++) begin
        if (reg_wr && reg_addr == 3'd2 && reg_wdata[i]) nds[i] = 0;
        if (ev[i]) nds[i] = 1;
      end
      if (reg_wr && reg_addr == 3'd1) m_mask = reg_wdata;
      if (reg_wr && reg_addr == 3'd3) m_en = reg_wdata;
      m_ds = nds; m_nis = nn; m_ais = na; m_pm = ev_pm; m_cnt = ev_cnt;
    end
  end

  function automatic bit [31:0] exp_rd(input bit [2:0] a);
    bit [31:0] r = 0;
    case (a)
      3'd0: begin r[3] = m_pm; r[4] = m_cnt; end
      3'd1: r = m_mask;
      3'd2: begin r[3:0] = m_ds; r[16] = m_nis; r[15] = m_ais; end
      3'd3: r = m_en;
      default: r = 0;
    endcase
    return r;
  endfunction

  task automatic compare();
    bit ew, es;
    bit [31:0] er;
    string rq;
    ew = m_pm && !m_mask[3];
    es = (m_nis && m_en[16]) || (m_ais && m_en[15]) || m_cnt || ew;
    er = exp_rd(reg_addr);
    vectors++;
    if (irq_wake !== ew) begin
      errors++;
      $display("FAIL %s irq_wake actual=%0b expected=%0b", rst_n ? "R3" : "R1", irq_wake, ew);
    end
    if (irq_sys !== es) begin
      errors++;
      $display("FAIL %s irq_sys actual=%0b expected=%0b", rst_n ? "R8" : "R1", irq_sys, es);
    end
    if (reg_rdata !== er) begin
      errors++;
      case (reg_addr)
        3'd0: rq = "R2";
        3'd2: rq = "R4 R5 R6 R7";
        default: rq = "R9";
      endcase
      if (!rst_n) rq = "R1";
      $display("FAIL %s rdata@%0d actual=%h expected=%h", rq, reg_addr, reg_rdata, er);
    end
  endtask

  task automatic step(input int ev_pct, input int wr_pct, input bit en_writes);
    @(negedge clk);
    compare();
    ev_tx     = ($urandom % 100) < ev_pct;
    ev_rxerr  = ($urandom % 100) < ev_pct;
    ev_txstop = ($urandom % 100) < ev_pct;
    ev_buserr = ($urandom % 100) < ev_pct;
    if (($urandom % 8) == 0) ev_pm = ~ev_pm;
    if (($urandom % 8) == 0) ev_cnt = ~ev_cnt;
    reg_addr = 3'($urandom);
    reg_wr = ($urandom % 100) < wr_pct;
    reg_wdata = ($urandom % 4 == 0) ? 32'hFFFF_FFFF : $urandom;
    if (reg_wr && !en_writes && (reg_addr == 3'd1 || reg_addr == 3'd3)) reg_addr = 3'd2;
  endtask

  task automatic wr(input bit [2:0] a, input bit [31:0] d);
    @(negedge clk);
    compare();
    {ev_tx, ev_rxerr, ev_txstop, ev_buserr} = '0;
    reg_wr = 1; reg_addr = a; reg_wdata = d;
  endtask

  initial begin
    // R1: reset state observed across every address
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      reg_addr = 3'(i);
      #1 compare();
    end
    @(negedge clk);
    rst_n = 1;
    // phase A: enables off (R2 R4 R5 R8)
    for (int i = 0; i < 3000; i++) step(10, 30, 0);
    // phase B: all enables on, wake masked (R3 R6 R7 R8)
    wr(3'd3, 32'hFFFF_FFFF);
    wr(3'd1, 32'h0000_0008);
    for (int i = 0; i < 3000; i++) step(8, 20, 0);
    // phase C: dense events, random writes everywhere (R5 R9)
    for (int i = 0; i < 6000; i++) step(40, 50, 1);
    @(negedge clk);
    compare();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule